// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block is the hazard and forwarding controller for a five-stage in-order pipeline whose conditional equality branches are decided in the decode stage. The branch target adder and the register-equality comparator both sit in decode, so the pipeline knows whether the branch is taken before the branch enters execute. The unit looks at the two source register numbers of the instruction in decode. It also looks at the destination number and the write and load flags of the instructions held in the execute, memory and write-back pipeline registers. It is purely combinational.

For each comparator operand the unit picks one of three sources: the register file, the EX/MEM result or the MEM/WB result. Some producers are too young for their result to reach the comparator in time. In that case the unit holds the PC and the IF/ID register, and it places a bubble into ID/EX. A branch stalls for one cycle behind an ALU producer. Behind a load it stalls for up to two cycles. Once the branch is no longer stalled and the comparator reports equal, the unit flushes the single instruction fetched after the branch. A not-taken branch costs nothing. An instruction in decode that is not a branch sees only the ordinary load-use rule.

Top module: `id_branch_hazard`

## Requirements
- R1: With no matching producer in any stage, hold_pc_ifid and bubble_idex are 0 and both comparator selects are 2'b00 (register file).
- R2: A source that matches the destination of a writing, non-load instruction in the memory stage selects 2'b01 (EX/MEM). A branch does not stall for it.
- R3: A source that matches only the destination of a writing instruction in the write-back stage selects 2'b10 (MEM/WB), with no stall. Select code 2'b11 never appears.
- R4: When the memory-stage and write-back-stage producers both match, the memory-stage result (2'b01) wins.
- R5: A branch whose source matches a writing instruction in execute raises hold_pc_ifid and bubble_idex, which are always equal.
- R6: A branch behind a load stalls while the load is in execute and again while it is in memory. When the load reaches write-back, the branch proceeds with select 2'b10.
- R7: Source register 0 never causes a stall or a select other than 2'b00.
- R8: flush_ifid is 1 only for a branch whose comparator reports equal in a cycle with no stall. It is 0 for a not-taken branch and 0 during a stall.
- R9: A non-branch instruction in decode stalls only when an execute-stage load (write and load flags both 1) matches one of its sources. ALU producers in execute and loads in memory do not stall it.
- R10: A producer whose register-write flag is 0 never causes a forward or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_branch | input | 1 | Decode-stage instruction is a conditional equality branch |
| id_cmp_equal | input | 1 | Decode-stage comparator result (operands equal) |
| id_rs | input | AW | First source register number in decode |
| id_rt | input | AW | Second source register number in decode |
| ex_dst | input | AW | Destination register in ID/EX |
| ex_reg_write | input | 1 | ID/EX instruction writes a register |
| ex_mem_read | input | 1 | ID/EX instruction is a load |
| mem_dst | input | AW | Destination register in EX/MEM |
| mem_reg_write | input | 1 | EX/MEM instruction writes a register |
| mem_mem_read | input | 1 | EX/MEM instruction is a load |
| wb_dst | input | AW | Destination register in MEM/WB |
| wb_reg_write | input | 1 | MEM/WB instruction writes a register |
| hold_pc_ifid | output | 1 | Hold PC and IF/ID this cycle |
| bubble_idex | output | 1 | Load ID/EX with all control bits zero |
| flush_ifid | output | 1 | Turn the IF/ID instruction into a nop (taken branch) |
| cmp_sel_a | output | 2 | Comparator operand A source: 00 regfile, 01 EX/MEM, 10 MEM/WB |
| cmp_sel_b | output | 2 | Comparator operand B source, same coding |

## Verification
The assertions assume that all inputs are known values. They also assume that a load always has its register-write flag set together with its load flag, because the non-branch stall check ties a stall to both flags. The stimulus drives each load with both flags high and drives ALU producers with the load flag low. Every input is set away from the clock edge before any output is sampled. Multi-cycle stalls are rebuilt by hand: the bench moves the same destination register from one stage's fields to the next, one step at a time.

// File: rtl/brhaz_pkg.sv
package brhaz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_EXMEM = 2'b01,
    SRC_MEMWB = 2'b10
  } cmp_src_e;
endpackage

// File: rtl/hazard_src_lane.sv
module hazard_src_lane
  import brhaz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_ld,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output cmp_src_e      sel,
  output logic          br_stall,
  output logic          lu_stall
);
  logic live, ex_hit, mem_hit, wb_hit;

  // register 0 is hard-wired and never creates a dependency
  assign live    = |src;
  assign ex_hit  = live && ex_wr  && (ex_dst  == src);
  assign mem_hit = live && mem_wr && (mem_dst == src);
  assign wb_hit  = live && wb_wr  && (wb_dst  == src);

  // a decode comparator cannot see an execute result, nor a load still in memory
  assign br_stall = ex_hit || (mem_hit && mem_ld);
  assign lu_stall = ex_hit && ex_ld;

  always_comb begin
    if (mem_hit) sel = mem_ld ? SRC_RF : SRC_EXMEM;  // younger result wins
    else if (wb_hit) sel = SRC_MEMWB;
    else sel = SRC_RF;
  end
endmodule

// File: rtl/hazard_merge.sv
module hazard_merge #(
  parameter int NSRC = 2
) (
  input  logic            is_branch,
  input  logic            cmp_equal,
  input  logic [NSRC-1:0] br_stall,
  input  logic [NSRC-1:0] lu_stall,
  output logic            stall,
  output logic            flush
);
  assign stall = is_branch ? (|br_stall) : (|lu_stall);
  // a stalled branch has not resolved yet, so it must not flush
  assign flush = is_branch && cmp_equal && !stall;
endmodule

// File: rtl/id_branch_hazard.sv
module id_branch_hazard
  import brhaz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          id_is_branch,
  input  logic          id_cmp_equal,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_reg_write,
  input  logic          ex_mem_read,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_reg_write,
  input  logic          mem_mem_read,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_reg_write,
  output logic          hold_pc_ifid,
  output logic          bubble_idex,
  output logic          flush_ifid,
  output logic [1:0]    cmp_sel_a,
  output logic [1:0]    cmp_sel_b
);
  localparam int NSRC = 2;

  logic [AW-1:0]   srcs [NSRC];
  cmp_src_e        sels [NSRC];
  logic [NSRC-1:0] br_v, lu_v;
  logic            stall;

  assign srcs[0] = id_rs;
  assign srcs[1] = id_rt;

  for (genvar g = 0; g < NSRC; g++) begin : g_lane
    hazard_src_lane #(.AW(AW)) u_lane (
      .src     (srcs[g]),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_reg_write),
      .ex_ld   (ex_mem_read),
      .mem_dst (mem_dst),
      .mem_wr  (mem_reg_write),
      .mem_ld  (mem_mem_read),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_reg_write),
      .sel     (sels[g]),
      .br_stall(br_v[g]),
      .lu_stall(lu_v[g])
    );
  end

  hazard_merge #(.NSRC(NSRC)) u_merge (
    .is_branch(id_is_branch),
    .cmp_equal(id_cmp_equal),
    .br_stall (br_v),
    .lu_stall (lu_v),
    .stall    (stall),
    .flush    (flush_ifid)
  );

  assign hold_pc_ifid = stall;
  assign bubble_idex  = stall;
  assign cmp_sel_a    = sels[0];
  assign cmp_sel_b    = sels[1];
endmodule

// File: rtl/brhaz_checker.sv
module brhaz_checker #(
  parameter int AW = 5
) (
  input logic          id_is_branch,
  input logic          id_cmp_equal,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic          ex_reg_write,
  input logic          ex_mem_read,
  input logic [AW-1:0] mem_dst,
  input logic          mem_reg_write,
  input logic          mem_mem_read,
  input logic          hold_pc_ifid,
  input logic          bubble_idex,
  input logic          flush_ifid,
  input logic [1:0]    cmp_sel_a,
  input logic [1:0]    cmp_sel_b
);
  always_comb begin
    assert_stall_bubble_R5: assert (hold_pc_ifid == bubble_idex)
      else $error("hold and bubble disagree");
    assert_no_flush_in_stall_R8: assert (!(flush_ifid && hold_pc_ifid))
      else $error("flush during stall");
    assert_flush_needs_taken_R8: assert (!flush_ifid || (id_is_branch && id_cmp_equal))
      else $error("flush without taken branch");
    assert_zero_reg_a_R7: assert ((id_rs != '0) || (cmp_sel_a == 2'b00))
      else $error("forward for r0 on A");
    assert_zero_reg_b_R7: assert ((id_rt != '0) || (cmp_sel_b == 2'b00))
      else $error("forward for r0 on B");
    assert_sel_code_R3: assert ((cmp_sel_a != 2'b11) && (cmp_sel_b != 2'b11))
      else $error("illegal select code");
    assert_exmem_source_R2: assert ((cmp_sel_a != 2'b01) ||
                                    (mem_reg_write && !mem_mem_read && mem_dst == id_rs))
      else $error("EX/MEM select without a matching ALU producer");
    assert_nonbranch_stall_R9: assert (id_is_branch || !hold_pc_ifid ||
                                       (ex_mem_read && ex_reg_write))
      else $error("non-branch stall without execute load");
  end
endmodule

bind id_branch_hazard brhaz_checker #(.AW(AW)) u_brhaz_chk (
  .id_is_branch (id_is_branch),
  .id_cmp_equal (id_cmp_equal),
  .id_rs        (id_rs),
  .id_rt        (id_rt),
  .ex_reg_write (ex_reg_write),
  .ex_mem_read  (ex_mem_read),
  .mem_dst      (mem_dst),
  .mem_reg_write(mem_reg_write),
  .mem_mem_read (mem_mem_read),
  .hold_pc_ifid (hold_pc_ifid),
  .bubble_idex  (bubble_idex),
  .flush_ifid   (flush_ifid),
  .cmp_sel_a    (cmp_sel_a),
  .cmp_sel_b    (cmp_sel_b)
);

// File: tb/tb_id_branch_hazard.sv
module tb_id_branch_hazard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          id_is_branch, id_cmp_equal;
  logic [AW-1:0] id_rs, id_rt, ex_dst, mem_dst, wb_dst;
  logic          ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write;
  logic          hold_pc_ifid, bubble_idex, flush_ifid;
  logic [1:0]    cmp_sel_a, cmp_sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  id_branch_hazard #(.AW(AW)) dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    id_is_branch = 0; id_cmp_equal = 0; id_rs = 0; id_rt = 0;
    ex_dst = 0; ex_reg_write = 0; ex_mem_read = 0;
    mem_dst = 0; mem_reg_write = 0; mem_mem_read = 0;
    wb_dst = 0; wb_reg_write = 0;
  endtask

  // inputs change on the falling edge, outputs are sampled just before the rising edge
  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input int st, input int fl, input int sa, input int sb);
    #(CLK_PERIOD/2 - 2);
    chk(tag, "hold", int'(hold_pc_ifid), st);
    chk(tag, "bubble", int'(bubble_idex), st);
    chk(tag, "flush", int'(flush_ifid), fl);
    chk(tag, "sel_a", int'(cmp_sel_a), sa);
    chk(tag, "sel_b", int'(cmp_sel_b), sb);
  endtask

  task automatic t_reset_state();
    settle(); idle();
    expect_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_no_hazard();
    settle(); idle();
    id_is_branch = 1; id_rs = 3; id_rt = 4;
    ex_dst = 7; ex_reg_write = 1; mem_dst = 8; mem_reg_write = 1; wb_dst = 9; wb_reg_write = 1;
    expect_out("R1", 0, 0, 0, 0);
  endtask

  task automatic t_fwd_exmem();
    settle(); idle();
    id_is_branch = 1; id_rs = 5; id_rt = 6; mem_dst = 5; mem_reg_write = 1;
    expect_out("R2", 0, 0, 1, 0);
    settle(); id_rs = 2; id_rt = 5;
    expect_out("R2", 0, 0, 0, 1);
  endtask

  task automatic t_fwd_memwb();
    settle(); idle();
    id_is_branch = 1; id_rs = 10; id_rt = 11; wb_dst = 11; wb_reg_write = 1;
    expect_out("R3", 0, 0, 0, 2);
  endtask

  task automatic t_priority();
    settle(); idle();
    id_is_branch = 1; id_rs = 12; id_rt = 12;
    mem_dst = 12; mem_reg_write = 1; wb_dst = 12; wb_reg_write = 1;
    expect_out("R4", 0, 0, 1, 1);
  endtask

  task automatic t_alu_stall();
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 1; id_rt = 4;
    ex_dst = 4; ex_reg_write = 1;
    expect_out("R5", 1, 0, 0, 0);
    // one cycle later the producer sits in memory: forward, resolve, flush
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 1; id_rt = 4;
    mem_dst = 4; mem_reg_write = 1;
    expect_out("R5", 0, 1, 0, 1);
  endtask

  task automatic t_load_two_cycles();
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 6; id_rt = 0;
    ex_dst = 6; ex_reg_write = 1; ex_mem_read = 1;
    expect_out("R6", 1, 0, 0, 0);
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 6;
    mem_dst = 6; mem_reg_write = 1; mem_mem_read = 1;
    expect_out("R6", 1, 0, 0, 0);
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 6;
    wb_dst = 6; wb_reg_write = 1;
    expect_out("R6", 0, 1, 2, 0);
  endtask

  task automatic t_reg_zero();
    settle(); idle();
    id_is_branch = 1; id_rs = 0; id_rt = 0;
    ex_dst = 0; ex_reg_write = 1; ex_mem_read = 1;
    mem_dst = 0; mem_reg_write = 1; wb_dst = 0; wb_reg_write = 1;
    expect_out("R7", 0, 0, 0, 0);
  endtask

  task automatic t_taken_flags();
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 2; id_rt = 3;
    expect_out("R8", 0, 1, 0, 0);
    settle(); id_cmp_equal = 0;
    expect_out("R8", 0, 0, 0, 0);
    settle(); id_is_branch = 0; id_cmp_equal = 1;
    expect_out("R8", 0, 0, 0, 0);
  endtask

  task automatic t_nonbranch();
    settle(); idle();
    id_rs = 9; id_rt = 1; ex_dst = 9; ex_reg_write = 1;
    expect_out("R9", 0, 0, 0, 0);
    settle(); idle();
    id_rs = 9; mem_dst = 9; mem_reg_write = 1; mem_mem_read = 1;
    expect_out("R9", 0, 0, 0, 0);
    settle(); idle();
    id_rs = 2; id_rt = 9; ex_dst = 9; ex_reg_write = 1; ex_mem_read = 1;
    expect_out("R9", 1, 0, 0, 0);
  endtask

  task automatic t_no_write();
    settle(); idle();
    id_is_branch = 1; id_cmp_equal = 1; id_rs = 13; id_rt = 14;
    ex_dst = 13; mem_dst = 14; wb_dst = 13;
    expect_out("R10", 0, 1, 0, 0);
  endtask

  initial begin
    idle();
    t_reset_state();
    t_no_hazard();
    t_fwd_exmem();
    t_fwd_memwb();
    t_priority();
    t_alu_stall();
    t_load_two_cycles();
    t_reg_zero();
    t_taken_flags();
    t_nonbranch();
    t_no_write();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule